// File: doc/BRIEF.md
# Scanline Memory Slot Arbiter

This block hands out the memory-access slots of one video scanline. A slot begins on each colour-clock tick, and the horizontal slot counter names it. For every slot the arbiter picks exactly one consumer. The consumers are disk, audio, sprite, bitplane, copper, blitter and CPU. Its output is a one-hot grant plus the number of words a bitplane fetch moves in that slot.

Disk, audio and sprite slots sit at fixed positions early in the line. Each is claimed only when its consumer or channel is enabled. Bitplane slots fall inside a programmable fetch window. Within that window, each group of slots carries a count of bitplane slots set by the plane count and the pixel resolution. A wide-fetch mode stretches each group, so each slot moves more words and more slots are left free. Any slot not taken by these reserved users goes to the copper if it asks, then to the blitter if it asks, and otherwise to the CPU.

Top module: `dma_slot_arbiter`

## Requirements
- R1: After reset, exactly one bit of `grant` is set at all times. The bit order is 0 disk, 1 audio, 2 sprite, 3 bitplane, 4 copper, 5 blitter, 6 CPU.
- R2: `grant` and `bpl_words` change only on a rising clock edge where `cck_tick` is 1. At that edge they take the decision for the `hpos` and configuration sampled at that same edge. While reset is held, `grant` is 7'b1000000 (CPU) and `bpl_words` is 0.
- R3: Slots 7, 9 and 11 go to disk when `en_disk` is 1. When `en_disk` is 0 they join the free pool.
- R4: Slot 13+2*i goes to audio when `en_aud[i]` is 1, for i = 0 to 3. When that bit is 0 the slot joins the free pool.
- R5: Slots 21+2*s and 22+2*s go to sprites when `en_spr[s]` is 1, for s = 0 to 7. When that bit is 0 both slots join the free pool.
- R6: A bitplane slot is taken when `en_bpl` is 1, the slot lies in the fetch window, and (hpos mod G) < U. U is `nplanes` times the resolution factor, limited to 8. The resolution factor is 1 for `res`=0, 2 for `res`=1, and 4 for `res`=2 or 3.
- R7: The group length is G = 8*M. M is 1 for `fmode`=0, 2 for `fmode`=1 or 2, and 4 for `fmode`=3. A larger M therefore divides the bitplane slots per line by M.
- R8: The fetch window covers the slots from `win_start` rounded down to a multiple of G, up to but excluding `win_stop`.
- R9: Priority order: fixed disk/audio/sprite slots, then bitplane, then copper (`cop_req`), then blitter (`blt_req`), then CPU.
- R10: `bpl_words` is M while a bitplane grant is active and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cck_tick | input | 1 | Colour-clock tick; starts a new slot |
| hpos | input | 8 | Horizontal slot counter |
| en_disk | input | 1 | Disk transfer enable |
| en_aud | input | 4 | Per-channel audio enables |
| en_spr | input | 8 | Per-sprite enables |
| en_bpl | input | 1 | Bitplane fetch enable |
| cop_req | input | 1 | Copper wants a slot |
| blt_req | input | 1 | Blitter wants a slot |
| nplanes | input | 4 | Number of bitplanes |
| res | input | 2 | Resolution: 0 low, 1 high, 2/3 super |
| fmode | input | 2 | Fetch width code |
| win_start | input | 8 | Fetch window first slot (before alignment) |
| win_stop | input | 8 | Fetch window end slot (exclusive) |
| grant | output | 7 | One-hot slot owner |
| bpl_words | output | 3 | Words per bitplane slot, 0 when not bitplane |

## Verification
Both outputs are registered once. Each result is therefore due on the clock edge where `cck_tick` is sampled high, and it stays put until the next such edge. The bench drives each vector on a falling edge with the tick raised. It drops the tick on the next falling edge, and at that point compares the outputs with its own model. It also moves `hpos` while the tick is low and confirms that nothing changes.

// File: rtl/dma_slot_pkg.sv
package dma_slot_pkg;

  localparam int NCONS = 7;

  typedef enum int {
    C_DISK = 0,
    C_AUD  = 1,
    C_SPR  = 2,
    C_BPL  = 3,
    C_COP  = 4,
    C_BLT  = 5,
    C_CPU  = 6
  } consumer_e;

  // words moved per bitplane slot; code 2 is reserved and behaves as code 1
  function automatic int fetch_mult(input logic [1:0] fm);
    case (fm)
      2'd0:    return 1;
      2'd3:    return 4;
      default: return 2;
    endcase
  endfunction

  function automatic int res_mult(input logic [1:0] r);
    case (r)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // bitplane slots used at the start of each group
  function automatic int bpl_used(input int np, input logic [1:0] r, input int cap);
    int p;
    p = np * res_mult(r);
    return (p > cap) ? cap : p;
  endfunction

endpackage

// File: rtl/dma_fixed_slots.sv
module dma_fixed_slots #(
  parameter int HPOS_W     = 8,
  parameter int DISK_SLOTS = 3,
  parameter int AUD_CH     = 4,
  parameter int SPR_N      = 8,
  parameter int DISK_BASE  = 7,
  parameter int AUD_BASE   = 13,
  parameter int SPR_BASE   = 21
) (
  input  logic [HPOS_W-1:0] hpos,
  input  logic              en_disk,
  input  logic [AUD_CH-1:0] en_aud,
  input  logic [SPR_N-1:0]  en_spr,
  output logic              hit_disk,
  output logic              hit_aud,
  output logic              hit_spr
);

  logic [DISK_SLOTS-1:0] dk;
  logic [AUD_CH-1:0]     au;
  logic [SPR_N-1:0]      sp;

  for (genvar k = 0; k < DISK_SLOTS; k++) begin : g_disk
    assign dk[k] = en_disk && (int'(hpos) == DISK_BASE + 2 * k);
  end

  for (genvar i = 0; i < AUD_CH; i++) begin : g_aud
    assign au[i] = en_aud[i] && (int'(hpos) == AUD_BASE + 2 * i);
  end

  for (genvar s = 0; s < SPR_N; s++) begin : g_spr
    assign sp[s] = en_spr[s] && ((int'(hpos) == SPR_BASE + 2 * s) ||
                                 (int'(hpos) == SPR_BASE + 2 * s + 1));
  end

  assign hit_disk = |dk;
  assign hit_aud  = |au;
  assign hit_spr  = |sp;

endmodule

// File: rtl/dma_bpl_window.sv
module dma_bpl_window
  import dma_slot_pkg::*;
#(
  parameter int HPOS_W      = 8,
  parameter int PLANE_W     = 4,
  parameter int GROUP_SLOTS = 8
) (
  input  logic [HPOS_W-1:0]  hpos,
  input  logic [HPOS_W-1:0]  win_start,
  input  logic [HPOS_W-1:0]  win_stop,
  input  logic [PLANE_W-1:0] nplanes,
  input  logic [1:0]         res,
  input  logic [1:0]         fmode,
  input  logic               en_bpl,
  output logic               in_win,
  output logic               hit_bpl,
  output logic [2:0]         words
);

  int mult, grp, mask, start_al, offs, used;

  always_comb begin
    mult     = fetch_mult(fmode);
    grp      = GROUP_SLOTS * mult;
    mask     = grp - 1;
    start_al = int'(win_start) & ~mask;
    offs     = int'(hpos) & mask;
    used     = bpl_used(int'(nplanes), res, GROUP_SLOTS);
    in_win   = (int'(hpos) >= start_al) && (int'(hpos) < int'(win_stop));
    hit_bpl  = en_bpl && in_win && (offs < used);
    words    = 3'(mult);
  end

endmodule

// File: rtl/dma_slot_arbiter.sv
module dma_slot_arbiter
  import dma_slot_pkg::*;
#(
  parameter int HPOS_W      = 8,
  parameter int PLANE_W     = 4,
  parameter int DISK_SLOTS  = 3,
  parameter int AUD_CH      = 4,
  parameter int SPR_N       = 8,
  parameter int DISK_BASE   = 7,
  parameter int AUD_BASE    = 13,
  parameter int SPR_BASE    = 21,
  parameter int GROUP_SLOTS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cck_tick,
  input  logic [HPOS_W-1:0]  hpos,
  input  logic               en_disk,
  input  logic [AUD_CH-1:0]  en_aud,
  input  logic [SPR_N-1:0]   en_spr,
  input  logic               en_bpl,
  input  logic               cop_req,
  input  logic               blt_req,
  input  logic [PLANE_W-1:0] nplanes,
  input  logic [1:0]         res,
  input  logic [1:0]         fmode,
  input  logic [HPOS_W-1:0]  win_start,
  input  logic [HPOS_W-1:0]  win_stop,
  output logic [NCONS-1:0]   grant,
  output logic [2:0]         bpl_words
);

  localparam logic [NCONS-1:0] GRANT_IDLE = NCONS'(1) << C_CPU;

  // internal events, brought out for the checker
  logic fix_disk, fix_aud, fix_spr;
  logic bpl_win, bpl_hit;
  logic [2:0] bpl_mult;
  logic [NCONS-1:0] grant_nxt;
  logic [2:0]       words_nxt;

  dma_fixed_slots #(
    .HPOS_W(HPOS_W), .DISK_SLOTS(DISK_SLOTS), .AUD_CH(AUD_CH), .SPR_N(SPR_N),
    .DISK_BASE(DISK_BASE), .AUD_BASE(AUD_BASE), .SPR_BASE(SPR_BASE)
  ) u_fixed (
    .hpos(hpos), .en_disk(en_disk), .en_aud(en_aud), .en_spr(en_spr),
    .hit_disk(fix_disk), .hit_aud(fix_aud), .hit_spr(fix_spr)
  );

  dma_bpl_window #(
    .HPOS_W(HPOS_W), .PLANE_W(PLANE_W), .GROUP_SLOTS(GROUP_SLOTS)
  ) u_bpl (
    .hpos(hpos), .win_start(win_start), .win_stop(win_stop),
    .nplanes(nplanes), .res(res), .fmode(fmode), .en_bpl(en_bpl),
    .in_win(bpl_win), .hit_bpl(bpl_hit), .words(bpl_mult)
  );

  always_comb begin
    grant_nxt = '0;
    words_nxt = '0;
    if (fix_disk)      grant_nxt[C_DISK] = 1'b1;
    else if (fix_aud)  grant_nxt[C_AUD]  = 1'b1;
    else if (fix_spr)  grant_nxt[C_SPR]  = 1'b1;
    else if (bpl_hit) begin
      grant_nxt[C_BPL] = 1'b1;
      words_nxt        = bpl_mult;
    end
    else if (cop_req)  grant_nxt[C_COP]  = 1'b1;
    else if (blt_req)  grant_nxt[C_BLT]  = 1'b1;
    else               grant_nxt[C_CPU]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant     <= GRANT_IDLE;
      bpl_words <= '0;
    end else if (cck_tick) begin
      grant     <= grant_nxt;
      bpl_words <= words_nxt;
    end
  end

endmodule

// File: rtl/dma_slot_arbiter_chk.sv
module dma_slot_arbiter_chk #(
  parameter int NC = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cck_tick,
  input logic [NC-1:0] grant,
  input logic [2:0]    bpl_words,
  input logic          fix_disk,
  input logic          bpl_win
);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !cck_tick |=> $stable(grant) && $stable(bpl_words)); // R2

  AST_DISK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cck_tick && fix_disk) |=> grant[0]); // R3

  AST_BPL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cck_tick && !bpl_win) |=> !grant[3]); // R8

  AST_WIDTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    grant[3] |-> (bpl_words == 3'd1 || bpl_words == 3'd2 || bpl_words == 3'd4)); // R10

  AST_WIDTH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !grant[3] |-> bpl_words == 3'd0); // R10

endmodule

bind dma_slot_arbiter dma_slot_arbiter_chk #(.NC(dma_slot_pkg::NCONS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cck_tick(cck_tick), .grant(grant),
  .bpl_words(bpl_words), .fix_disk(fix_disk), .bpl_win(bpl_win)
);

// File: tb/dma_slot_arbiter_tb.sv
module dma_slot_arbiter_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cck_tick = 1'b0;
  logic [7:0] hpos = '0;
  logic       en_disk = 1'b0;
  logic [3:0] en_aud = '0;
  logic [7:0] en_spr = '0;
  logic       en_bpl = 1'b0;
  logic       cop_req = 1'b0;
  logic       blt_req = 1'b0;
  logic [3:0] nplanes = '0;
  logic [1:0] res = '0;
  logic [1:0] fmode = '0;
  logic [7:0] win_start = '0;
  logic [7:0] win_stop = '0;
  logic [6:0] grant;
  logic [2:0] bpl_words;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_slot_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cck_tick(cck_tick), .hpos(hpos),
    .en_disk(en_disk), .en_aud(en_aud), .en_spr(en_spr), .en_bpl(en_bpl),
    .cop_req(cop_req), .blt_req(blt_req), .nplanes(nplanes), .res(res),
    .fmode(fmode), .win_start(win_start), .win_stop(win_stop),
    .grant(grant), .bpl_words(bpl_words)
  );

  // owner index: 0 disk 1 audio 2 sprite 3 bitplane 4 copper 5 blitter 6 cpu
  function automatic int owner(input int h);
    int m, g, lo, u;
    for (int k = 0; k < 3; k++) if (en_disk && h == 7 + 2 * k) return 0;
    for (int i = 0; i < 4; i++) if (en_aud[i] && h == 13 + 2 * i) return 1;
    for (int s = 0; s < 8; s++)
      if (en_spr[s] && (h == 21 + 2 * s || h == 22 + 2 * s)) return 2;
    m  = (fmode == 2'd0) ? 1 : ((fmode == 2'd3) ? 4 : 2);
    g  = 8 * m;
    lo = (int'(win_start) / g) * g;
    u  = int'(nplanes) * ((res == 2'd0) ? 1 : ((res == 2'd1) ? 2 : 4));
    if (u > 8) u = 8;
    if (en_bpl && h >= lo && h < int'(win_stop) && (h % g) < u) return 3;
    if (cop_req) return 4;
    if (blt_req) return 5;
    return 6;
  endfunction

  function automatic int mult_of(input logic [1:0] f);
    if (f == 2'd0) return 1;
    if (f == 2'd3) return 4;
    return 2;
  endfunction

  task automatic check(input string rq, input logic [6:0] eg, input logic [2:0] ew);
    n_vec++;
    if (grant !== eg || bpl_words !== ew) begin
      n_bad++;
      $display("FAIL %s hpos=%0d grant=%b/%0d expected %b/%0d",
               rq, hpos, grant, bpl_words, eg, ew);
    end
  endtask

  task automatic apply(input int h, input string rq);
    int o;
    @(negedge clk);
    hpos = 8'(h);
    cck_tick = 1'b1;
    o = owner(h);
    @(negedge clk);
    cck_tick = 1'b0;
    check(rq, 7'(1) << o, (o == 3) ? 3'(mult_of(fmode)) : 3'd0);
  endtask

  task automatic sweep(input string rq);
    for (int h = 0; h < 227; h++) apply(h, rq);
  endtask

  int bpl_cnt [4];

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R2 reset", 7'b1000000, 3'd0);
    rst_n = 1'b1;

    // R3 R4 R5: every fixed consumer on, bitplanes off
    en_disk = 1'b1; en_aud = 4'hF; en_spr = 8'hFF;
    sweep("R3/R4/R5 all fixed on");
    // disabled consumers release slots to the free pool (blitter here)
    en_disk = 1'b0; en_aud = 4'b0101; en_spr = 8'b1010_0110; blt_req = 1'b1;
    sweep("R3/R4/R5 partial enables");

    // R6 R8 R10 lowres 5 planes, unaligned window start
    en_disk = 1'b1; en_aud = 4'hF; en_spr = 8'hFF; blt_req = 1'b0;
    en_bpl = 1'b1; nplanes = 4'd5; res = 2'd0; fmode = 2'd0;
    win_start = 8'd59; win_stop = 8'd212;
    sweep("R6/R8 lowres 1x");
    // R7 R8 4x fetch aligns start to 32
    fmode = 2'd3;
    sweep("R7/R8 lowres 4x");
    // R9 copper beats blitter, hires 4 planes fills group
    cop_req = 1'b1; blt_req = 1'b1; res = 2'd1; nplanes = 4'd4; fmode = 2'd0;
    sweep("R9/R6 hires priority");
    // R6 clamp: super res 8 planes limited to 8 slots
    cop_req = 1'b0; res = 2'd3; nplanes = 4'd8; fmode = 2'd1;
    sweep("R6/R10 super clamp 2x");

    // R7: reserved fetch code 2 behaves as code 1, counted per line
    nplanes = 4'd3; res = 2'd0; win_start = 8'd64; win_stop = 8'd192;
    en_disk = 1'b0; en_aud = '0; en_spr = '0;
    for (int f = 0; f < 4; f++) begin
      fmode = 2'(f);
      bpl_cnt[f] = 0;
      for (int h = 0; h < 227; h++) begin
        apply(h, "R7 fetch code");
        if (grant[3]) bpl_cnt[f]++;
      end
    end
    n_vec++;
    if (bpl_cnt[0] != 48 || bpl_cnt[1] != 24 || bpl_cnt[2] != 24 || bpl_cnt[3] != 12) begin
      n_bad++;
      $display("FAIL R7 slot counts %0d %0d %0d %0d expected 48 24 24 12",
               bpl_cnt[0], bpl_cnt[1], bpl_cnt[2], bpl_cnt[3]);
    end

    // R2: moving hpos without a tick leaves outputs alone
    fmode = 2'd0;
    apply(64, "R2 setup");
    @(negedge clk); hpos = 8'd70;
    @(negedge clk); hpos = 8'd9; en_disk = 1'b1;
    @(negedge clk);
    check("R2 no tick hold", 7'b0001000, 3'd1);

    // random configurations, each swept across a line
    for (int r = 0; r < 14; r++) begin
      en_disk = 1'($urandom); en_aud = 4'($urandom); en_spr = 8'($urandom);
      en_bpl = 1'($urandom); cop_req = 1'($urandom); blt_req = 1'($urandom);
      nplanes = 4'($urandom_range(0, 9)); res = 2'($urandom);
      fmode = 2'($urandom); win_start = 8'($urandom_range(20, 120));
      win_stop = 8'($urandom_range(100, 226));
      sweep("R1/R6/R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule